// File: doc/BRIEF.md
# ASCII Hex Command Parser

This block sits behind a serial receiver and turns a stream of printable characters into command words for a debug bus master. A command letter opens a command and picks its kind: load an address, read, or write. The hex digits after it are shifted into a value, and the first character that is not a hex digit closes the command. The block then emits the opcode, the value and an address-stepping flag for one cycle.

Two address letters exist. One marks the new address as stepping after each access, and the other marks it as fixed. Reads and writes report the stepping mode of the most recent address command, so the bus master knows whether a run of reads walks through memory or polls one register. Idle filler bytes that a link sends when it has nothing to say are dropped without touching any state.

Upper-case `A` is always a command, so the digit value ten must be sent as lower-case `a`. Every other hex letter may be sent in either case.

Top module: `hexcmd_parser`

## Requirements
- R1: After a synchronous reset, `cmd_valid` is low, no command is open, and the address mode is fixed (`cmd_inc` reports 0 until an address command changes it).
- R2: Byte 0x41 (`A`) opens an address command with stepping. It is emitted with `cmd_op` = 1 and `cmd_inc` = 1, and it sets the mode to stepping.
- R3: Byte 0x53 (`S`) opens an address command without stepping. It is emitted with `cmd_op` = 1 and `cmd_inc` = 0, and it sets the mode to fixed.
- R4: Byte 0x52 (`R`) opens a read, emitted with `cmd_op` = 2. Its `cmd_inc` equals the mode left by the last emitted address command.
- R5: Byte 0x57 (`W`) opens a write, emitted with `cmd_op` = 3, with the gathered value in `cmd_data` and `cmd_inc` set to the current mode.
- R6: The hex digits are `0`-`9`, `a`-`f` and `B`-`F`. Each digit shifts into the value as its new low nibble, so the first digit received ends up most significant.
- R7: Any byte that is neither a digit nor filler ends the open command. `cmd_valid` is high for exactly the one cycle that follows the clock edge accepting that byte. Newline (0x0A) is the usual terminator.
- R8: Filler bytes 0x7F and 0xFF change nothing. A value split by filler equals the same value sent without it, and filler never produces a command.
- R9: If more than 8 digits are sent, only the last 8 are kept (the low 32 bits).
- R10: A command letter that arrives while a command is open first emits the open command, then opens its own.
- R11: Digits that arrive while no command is open are discarded. A terminator with no open command emits nothing.
- R12: The value clears after every terminator, so a command with no digits is emitted with `cmd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | `rx_byte` holds a received character this cycle |
| rx_byte | input | 8 | Received character |
| cmd_valid | output | 1 | One-cycle strobe marking a finished command |
| cmd_op | output | 2 | Opcode: 1 address, 2 read, 3 write |
| cmd_data | output | DATA_W | Gathered value (address or write data) |
| cmd_inc | output | 1 | Address stepping flag for this command |

## Verification
On every cycle the assertions check four things. Filler never produces a strobe and never changes the open command. A strobe always carries a real opcode and follows a terminator by exactly one cycle. Each accepted digit lands in the low nibble while the older nibbles move up. A read or write reports the stored address mode. Only the bench's scenarios can show the full values gathered across many bytes: truncation of long digit runs, how a mid-word command letter splits two commands, digits dropped while nothing is open, and how the mode chosen by one address command carries into later reads and writes.

// File: rtl/hexcmd_pkg.sv
package hexcmd_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_ADDR  = 2'd1,
    OP_READ  = 2'd2,
    OP_WRITE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    CL_FILL,
    CL_DIGIT,
    CL_ADDR_STEP,
    CL_ADDR_HOLD,
    CL_READ,
    CL_WRITE,
    CL_OTHER
  } cls_e;

  localparam int NIB_W = 4;

  localparam logic [7:0] CH_FILL_LO   = 8'h7F;
  localparam logic [7:0] CH_FILL_HI   = 8'hFF;
  localparam logic [7:0] CH_ADDR_STEP = 8'h41;
  localparam logic [7:0] CH_ADDR_HOLD = 8'h53;
  localparam logic [7:0] CH_READ      = 8'h52;
  localparam logic [7:0] CH_WRITE     = 8'h57;

  function automatic op_e letter_op(input cls_e c);
    case (c)
      CL_ADDR_STEP, CL_ADDR_HOLD: letter_op = OP_ADDR;
      CL_READ:                    letter_op = OP_READ;
      CL_WRITE:                   letter_op = OP_WRITE;
      default:                    letter_op = OP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/hexcmd_classify.sv
module hexcmd_classify
  import hexcmd_pkg::*;
(
  input  logic [7:0]       ch,
  output cls_e             cls,
  output logic [NIB_W-1:0] nib
);

  always_comb begin
    cls = CL_OTHER;
    nib = '0;
    if (ch == CH_FILL_LO || ch == CH_FILL_HI) begin
      cls = CL_FILL;
    end else if (ch >= 8'h30 && ch <= 8'h39) begin
      cls = CL_DIGIT;
      nib = ch[3:0];
    end else if ((ch >= 8'h61 && ch <= 8'h66) || (ch >= 8'h42 && ch <= 8'h46)) begin
      cls = CL_DIGIT;
      nib = ch[3:0] + 4'd9;
    end else begin
      case (ch)
        CH_ADDR_STEP: cls = CL_ADDR_STEP;
        CH_ADDR_HOLD: cls = CL_ADDR_HOLD;
        CH_READ:      cls = CL_READ;
        CH_WRITE:     cls = CL_WRITE;
        default:      cls = CL_OTHER;
      endcase
    end
  end

  // R6: upper-case A is a command letter, never a digit
  always_comb begin
    assert_upper_a_is_cmd_R6: assert (!(ch == CH_ADDR_STEP && cls == CL_DIGIT));
  end

endmodule

// File: rtl/hexcmd_accum.sv
module hexcmd_accum
  import hexcmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              clear,
  input  logic [NIB_W-1:0]  nib,
  output logic [DATA_W-1:0] acc
);

  logic [DATA_W-1:0] acc_q;
  assign acc = acc_q;

  generate
    if (DATA_W > NIB_W) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst || clear)  acc_q <= '0;
        else if (shift_en) acc_q <= {acc_q[DATA_W-NIB_W-1:0], nib};
      end

      assert_shift_order_R6: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !clear) |=>
          (acc_q[NIB_W-1:0] == $past(nib)) &&
          (acc_q[DATA_W-1:NIB_W] == $past(acc_q[DATA_W-NIB_W-1:0])));
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst || clear)  acc_q <= '0;
        else if (shift_en) acc_q <= DATA_W'(nib);
      end
    end
  endgenerate

  assert_clear_after_end_R12: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc_q == '0));

endmodule

// File: rtl/hexcmd_ctrl.sv
module hexcmd_ctrl
  import hexcmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  cls_e              cls,
  input  logic [DATA_W-1:0] acc,
  output logic              accept_digit,
  output logic              end_word,
  output logic              out_valid,
  output op_e               out_op,
  output logic [DATA_W-1:0] out_data,
  output logic              out_inc
);

  op_e  pend_op;
  logic pend_step;
  logic mode_step;

  always_comb begin
    end_word     = byte_valid && (cls != CL_FILL) && (cls != CL_DIGIT);
    accept_digit = byte_valid && (cls == CL_DIGIT) && (pend_op != OP_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_op   <= OP_NONE;
      pend_step <= 1'b0;
      mode_step <= 1'b0;
      out_valid <= 1'b0;
      out_op    <= OP_NONE;
      out_data  <= '0;
      out_inc   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (end_word) begin
        if (pend_op != OP_NONE) begin
          out_valid <= 1'b1;
          out_op    <= pend_op;
          out_data  <= acc;
          if (pend_op == OP_ADDR) begin
            out_inc   <= pend_step;
            mode_step <= pend_step;
          end else begin
            out_inc   <= mode_step;
          end
        end
        pend_op   <= letter_op(cls);
        pend_step <= (cls == CL_ADDR_STEP);
      end
    end
  end

  assert_fill_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && cls == CL_FILL) |=> (!out_valid && $stable(pend_op) && $stable(mode_step)));

  assert_valid_has_op_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_op != OP_NONE));

  assert_strobe_after_end_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(end_word));

  assert_mode_reported_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_op != OP_ADDR) |-> (out_inc == mode_step));

endmodule

// File: rtl/hexcmd_parser.sv
module hexcmd_parser #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic              cmd_valid,
  output logic [1:0]        cmd_op,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_inc
);
  import hexcmd_pkg::*;

  cls_e              cls;
  logic [NIB_W-1:0]  nib;
  logic              accept_digit;
  logic              end_word;
  logic [DATA_W-1:0] acc;
  op_e               op_q;

  hexcmd_classify u_classify (
    .ch  (rx_byte),
    .cls (cls),
    .nib (nib)
  );

  hexcmd_accum #(.DATA_W(DATA_W)) u_accum (
    .clk      (clk),
    .rst      (rst),
    .shift_en (accept_digit),
    .clear    (end_word),
    .nib      (nib),
    .acc      (acc)
  );

  hexcmd_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .byte_valid   (rx_valid),
    .cls          (cls),
    .acc          (acc),
    .accept_digit (accept_digit),
    .end_word     (end_word),
    .out_valid    (cmd_valid),
    .out_op       (op_q),
    .out_data     (cmd_data),
    .out_inc      (cmd_inc)
  );

  assign cmd_op = op_q;

endmodule

// File: tb/hexcmd_parser_bench.sv
`timescale 1ns/1ps
module hexcmd_parser_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = 8'h00;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic [31:0] cmd_data;
  logic        cmd_inc;

  always #4 clk = ~clk;

  hexcmd_parser u_hexcmd_parser (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_inc(cmd_inc)
  );

  int n_vec = 0;
  int n_bad = 0;
  string cur_req = "R1";

  // reference model state
  int          m_open = 0;   // 0 none, 1 addr, 2 read, 3 write
  bit          m_step = 0;
  bit          m_mode = 0;
  bit [31:0]   m_val  = 0;
  bit          e_valid = 0;
  int          e_op = 0;
  bit [31:0]   e_data = 0;
  bit          e_inc = 0;

  function automatic int digit_of(input byte b);
    if (b >= "0" && b <= "9") return b - "0";
    if (b >= "a" && b <= "f") return b - "a" + 10;
    if (b >= "B" && b <= "F") return b - "A" + 10;
    return -1;
  endfunction

  task automatic model(input bit v, input byte b);
    int d;
    e_valid = 0;
    if (!v) return;
    if (b == 8'h7F || b == 8'hFF) return;
    d = digit_of(b);
    if (d >= 0) begin
      if (m_open != 0) m_val = {m_val[27:0], 4'(d)};
      return;
    end
    if (m_open != 0) begin
      e_valid = 1;
      e_op    = m_open;
      e_data  = m_val;
      if (m_open == 1) begin e_inc = m_step; m_mode = m_step; end
      else e_inc = m_mode;
    end
    m_val = 0;
    case (b)
      "A":     begin m_open = 1; m_step = 1; end
      "S":     begin m_open = 1; m_step = 0; end
      "R":     m_open = 2;
      "W":     m_open = 3;
      default: m_open = 0;
    endcase
  endtask

  task automatic compare();
    n_vec++;
    if (cmd_valid !== e_valid) begin
      n_bad++;
      $display("FAIL %s: cmd_valid=%0b expected %0b", cur_req, cmd_valid, e_valid);
    end else if (e_valid && (cmd_op !== 2'(e_op) || cmd_data !== e_data || cmd_inc !== e_inc)) begin
      n_bad++;
      $display("FAIL %s: op=%0d data=%h inc=%0b expected op=%0d data=%h inc=%0b",
               cur_req, cmd_op, cmd_data, cmd_inc, e_op, e_data, e_inc);
    end
  endtask

  task automatic cycle(input bit v, input byte b);
    @(negedge clk);
    compare();
    rx_valid = v;
    rx_byte  = b;
    model(v, b);
  endtask

  task automatic send(input string s, input int gap);
    for (int i = 0; i < s.len(); i++) begin
      cycle(1'b1, s[i]);
      for (int g = 0; g < gap; g++) cycle(1'b0, 8'h00);
    end
  endtask

  initial begin
    #1_200_000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state, then a read reports fixed mode
    cur_req = "R1";
    cycle(1'b0, 8'h00);
    send("R\n", 0);
    cur_req = "R2";  send("A1234\n", 0);
    cur_req = "R4";  send("R\nR\n", 0);
    cur_req = "R3";  send("S00ff\n", 1);
    cur_req = "R4";  send("R\n", 0);
    cur_req = "R5";  send("Wdeadbeef\n", 0);
    cur_req = "R6";  send("W9BCDEF\nW0123\n", 2);
    cur_req = "R8";
    cycle(1'b1, "W"); cycle(1'b1, "1"); cycle(1'b1, 8'h7F); cycle(1'b1, "2");
    cycle(1'b1, 8'hFF); cycle(1'b1, 8'hFF); cycle(1'b1, "3"); cycle(1'b1, "\n");
    cycle(1'b1, 8'h7F); cycle(1'b1, 8'hFF);
    cur_req = "R9";  send("W123456789\nAfedcba9876\n", 0);
    cur_req = "R10"; send("W5R\nA10A20\nS7W8 ", 0);
    cur_req = "R11"; send("77\nx\n\n", 0);
    cur_req = "R12"; send("W99\nW\nA\n", 0);
    cur_req = "R7";  send("R R,R\n", 0);
    for (int k = 0; k < 4; k++) cycle(1'b0, 8'h00);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule